// File: doc/BRIEF.md
# Parity-Checked Serial Register Port

This block is a 16-bit serial slave port that gives a host controller access to a small register set: a read-only angle word fed from a sensor core, a one-bit configuration register that selects the interrupt gate mode, and a software-reset trigger. The host drives the serial clock, an active-low select, and a data line into the block. The block returns data on a separate output line and drives an output-enable for the pad. All four serial inputs are oversampled by the local system clock. Each frame is sixteen bits, sent and returned most significant bit first. A 14-bit payload fills bits 15:2 and bit 0 makes the whole frame even parity. The block takes input bits on the falling serial-clock edge and moves its output on the rising edge.

The port is pipelined. The word returned during a frame is the answer to the previous frame. A write therefore takes two frames: the command, then a data frame carrying the value. Every incoming frame is checked for parity, for a known command and for exactly sixteen clocks. Any violation sets an error flag. The flag is reported in bit 1 of every response and stays set until the host clears it with a dedicated read command.

Top module: `spi_reg_port`

## Requirements
- R1: After reset the first frame returns 0x0000, the error flag is clear and `intMode` is 0.
- R2: `misoOe` is 1 only while the select is low. The output bit 15 is valid from the select falling edge, and each later rising serial-clock edge presents the next lower bit.
- R3: Each response frame carries the payload in bits 15:2, the error flag in bit 1 and even parity in bit 0. It answers the previous frame. A read of address 0x3FFF returns the angle in payload bits 9:0, the high-field alarm in payload bit 10 and the low-field alarm in payload bit 11.
- R4: A write command to the configuration address 0x3F20 is followed by a data frame whose payload bit 0 (frame bit 2) becomes `intMode`. The frame after the command returns the old value, and the frame after the data frame returns the new value.
- R5: A frame with odd parity sets the error flag and is not executed; in particular, a bad-parity write command does not make the next frame a data frame.
- R6: A command to an undecoded address, a write to the read-only angle address 0x3FFF, or a write to the clear address sets the error flag. Its response payload is zero.
- R7: A frame closed after any clock count other than 16 sets the error flag and is discarded.
- R8: The error flag stays set across frames until a read of address 0x3380. That read returns 0x0000.
- R9: The all-zero frame (address 0x0000) is a no-operation and returns 0x0000 while no error is present.
- R10: A write to address 0x3C00 followed by a data frame gives one `softRstPulse` of one clock. If the data frame's payload bit 0 (frame bit 2) is 1, the configuration register and the error flag also return to reset. If it is 0, they are kept.
- R11: Every loaded response word has even parity over all 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| ssN | input | 1 | Active-low frame select from the host |
| mosi | input | 1 | Serial data from the host |
| angle | input | ANGLE_W | Angle value from the sensor core |
| alarmLo | input | 1 | Field-too-weak alarm from the core |
| alarmHi | input | 1 | Field-too-strong alarm from the core |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for the serial data pad |
| intMode | output | 1 | Interrupt gate mode from the configuration register |
| softRstPulse | output | 1 | One-clock software reset request to the core |

## Verification
On every clock, the embedded assertions check these properties:
- the error flag sets when an error is raised and holds until it is cleared or reset;
- each loaded response has even parity;
- the configuration register changes only on a write or an interface reset;
- the frame-end actions are mutually exclusive.

Only the bench's frame sequences can show the rest:
- the one-frame response lag;
- the old and new values returned around a write;
- the discarding of short, long and bad-parity frames;
- the different effects of the two software-reset variants.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int FRAME_BITS = 16;
  localparam int PAY_W      = FRAME_BITS - 2;
  localparam int RES_BIT    = 2;

  localparam logic [PAY_W-1:0] ADDR_NOP    = 14'h0000;
  localparam logic [PAY_W-1:0] ADDR_ANGLE  = 14'h3FFF;
  localparam logic [PAY_W-1:0] ADDR_CFG    = 14'h3F20;
  localparam logic [PAY_W-1:0] ADDR_SWRST  = 14'h3C00;
  localparam logic [PAY_W-1:0] ADDR_CLRERR = 14'h3380;

  typedef enum logic [1:0] {
    RESP_ZERO  = 2'd0,
    RESP_ANGLE = 2'd1,
    RESP_CFG   = 2'd2
  } resp_sel_e;

  typedef struct packed {
    logic      rxBit;
    logic      shiftIn;
    logic      shiftOut;
    logic      loadResp;
    resp_sel_e respSel;
    logic      setErr;
    logic      clrErr;
    logic      wrCfg;
    logic      softRst;
    logic      spiRst;
  } strobes_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sck,
  input  logic                  ssN,
  input  logic                  mosi,
  input  logic [FRAME_BITS-1:0] rxWord,
  output strobes_t              strb,
  output logic                  ssActive
);
  localparam int CNT_W = $clog2(FRAME_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [SYNC_STAGES:0] sckSh, ssSh, mosiSh;
  logic sckNow, sckOld, ssNow, ssOld;
  logic ssFall, ssRise, sckRise, sckFall;
  logic [CNT_W-1:0] bitCnt;
  logic roseSeen, expectData, pendCfg, expNxt, pendNxt;
  logic [PAY_W-1:0] cmdAddr;
  logic cmdRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh  <= '0;
      ssSh   <= '1;
      mosiSh <= '0;
    end else begin
      sckSh  <= {sckSh[SYNC_STAGES-1:0], sck};
      ssSh   <= {ssSh[SYNC_STAGES-1:0], ssN};
      mosiSh <= {mosiSh[SYNC_STAGES-1:0], mosi};
    end
  end

  assign sckNow   = sckSh[SYNC_STAGES-1];
  assign sckOld   = sckSh[SYNC_STAGES];
  assign ssNow    = ssSh[SYNC_STAGES-1];
  assign ssOld    = ssSh[SYNC_STAGES];
  assign ssActive = ~ssNow;
  assign ssFall   = ssOld & ~ssNow;
  assign ssRise   = ~ssOld & ssNow;
  assign sckRise  = ssActive & sckNow & ~sckOld;
  assign sckFall  = ssActive & ~sckNow & sckOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      roseSeen   <= 1'b0;
      expectData <= 1'b0;
      pendCfg    <= 1'b0;
    end else begin
      if (ssFall) begin
        bitCnt   <= '0;
        roseSeen <= 1'b0;
      end else begin
        if (sckFall && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
        if (sckRise) roseSeen <= 1'b1;
      end
      if (strb.loadResp) begin
        expectData <= expNxt;
        pendCfg    <= pendNxt;
      end
    end
  end

  assign cmdAddr = rxWord[FRAME_BITS-2:1];
  assign cmdRead = rxWord[FRAME_BITS-1];

  always_comb begin
    strb          = '0;
    strb.respSel  = RESP_ZERO;
    strb.rxBit    = mosiSh[SYNC_STAGES-1];
    strb.shiftIn  = sckFall;
    strb.shiftOut = sckRise & roseSeen;
    expNxt        = 1'b0;
    pendNxt       = 1'b0;
    if (ssRise) begin
      strb.loadResp = 1'b1;
      if (bitCnt != CNT_FULL || (^rxWord)) begin
        strb.setErr = 1'b1;
      end else if (expectData) begin
        if (pendCfg) begin
          strb.wrCfg   = 1'b1;
          strb.respSel = RESP_CFG;
        end else begin
          strb.softRst = 1'b1;
          strb.spiRst  = rxWord[RES_BIT];
        end
      end else if (cmdAddr == ADDR_NOP) begin
        strb.respSel = RESP_ZERO;
      end else if (cmdAddr == ADDR_ANGLE) begin
        if (cmdRead) strb.respSel = RESP_ANGLE;
        else         strb.setErr  = 1'b1;
      end else if (cmdAddr == ADDR_CFG) begin
        strb.respSel = RESP_CFG;
        if (!cmdRead) begin
          expNxt  = 1'b1;
          pendNxt = 1'b1;
        end
      end else if (cmdAddr == ADDR_SWRST) begin
        if (!cmdRead) expNxt = 1'b1;
      end else if (cmdAddr == ADDR_CLRERR) begin
        if (cmdRead) strb.clrErr = 1'b1;
        else         strb.setErr = 1'b1;
      end else begin
        strb.setErr = 1'b1;
      end
    end
  end

  // R10: frame-end actions never combine
  p_excl_actions_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCfg, strb.softRst, strb.clrErr, strb.setErr}));

  // R2: no shifting on the cycle the frame closes
  p_no_shift_at_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadResp |-> !(strb.shiftOut || strb.shiftIn));
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int   ANGLE_W   = 10,
  parameter logic CFG_RESET = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [ANGLE_W-1:0]    angle,
  input  logic                  alarmLo,
  input  logic                  alarmHi,
  output logic [FRAME_BITS-1:0] rxWord,
  output logic                  txMsb,
  output logic                  intMode,
  output logic                  softRstPulse
);
  localparam int PAD_W = PAY_W - ANGLE_W - 2;

  logic [FRAME_BITS-1:0] rxReg, txReg, respWord;
  logic                  errFlag, errNxt, cfgReg, cfgNxt;
  logic [PAY_W-1:0]      payload, angleWord;

  generate
    if (PAD_W > 0) begin : g_pad
      assign angleWord = {{PAD_W{1'b0}}, alarmLo, alarmHi, angle};
    end else begin : g_nopad
      assign angleWord = {alarmLo, alarmHi, angle};
    end
  endgenerate

  always_comb begin
    errNxt = errFlag;
    if (strb.spiRst)      errNxt = 1'b0;
    else if (strb.setErr) errNxt = 1'b1;
    else if (strb.clrErr) errNxt = 1'b0;
    cfgNxt = cfgReg;
    if (strb.spiRst)     cfgNxt = CFG_RESET;
    else if (strb.wrCfg) cfgNxt = rxReg[RES_BIT];
    case (strb.respSel)
      RESP_ANGLE: payload = angleWord;
      RESP_CFG:   payload = {{(PAY_W-1){1'b0}}, cfgNxt};
      default:    payload = '0;
    endcase
    respWord = {payload, errNxt, ^{payload, errNxt}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg        <= '0;
      txReg        <= '0;
      errFlag      <= 1'b0;
      cfgReg       <= CFG_RESET;
      softRstPulse <= 1'b0;
    end else begin
      if (strb.shiftIn) rxReg <= {rxReg[FRAME_BITS-2:0], strb.rxBit};
      if (strb.loadResp)      txReg <= respWord;
      else if (strb.shiftOut) txReg <= {txReg[FRAME_BITS-2:0], 1'b0};
      if (strb.loadResp) begin
        errFlag <= errNxt;
        cfgReg  <= cfgNxt;
      end
      softRstPulse <= strb.softRst;
    end
  end

  assign rxWord  = rxReg;
  assign txMsb   = txReg[FRAME_BITS-1];
  assign intMode = cfgReg;

  // R5: a raised error is visible the next cycle
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> errFlag);

  // R8: the flag holds unless cleared or reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.clrErr && !strb.spiRst) |=> errFlag);

  // R11: loaded responses carry even parity
  p_resp_parity_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadResp |=> (^txReg == 1'b0));

  // R4: configuration changes only on a write or interface reset
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCfg && !strb.spiRst) |=> $stable(cfgReg));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_port_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   ANGLE_W     = 10,
  parameter logic CFG_RESET   = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sck,
  input  logic               ssN,
  input  logic               mosi,
  input  logic [ANGLE_W-1:0] angle,
  input  logic               alarmLo,
  input  logic               alarmHi,
  output logic               miso,
  output logic               misoOe,
  output logic               intMode,
  output logic               softRstPulse
);
  strobes_t              strb;
  logic                  ssActive, txMsb;
  logic [FRAME_BITS-1:0] rxWord;

  spi_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ssN), .mosi(mosi),
    .rxWord(rxWord), .strb(strb), .ssActive(ssActive)
  );

  spi_port_dp #(.ANGLE_W(ANGLE_W), .CFG_RESET(CFG_RESET)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .angle(angle),
    .alarmLo(alarmLo), .alarmHi(alarmHi), .rxWord(rxWord),
    .txMsb(txMsb), .intMode(intMode), .softRstPulse(softRstPulse)
  );

  assign misoOe = ssActive;
  assign miso   = ssActive & txMsb;
endmodule

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;
  localparam int HALF = 24;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, ssN = 1'b1, mosi = 1'b0;
  logic [9:0] angle = 10'h2A5;
  logic alarmLo = 1'b0, alarmHi = 1'b1;
  logic miso, misoOe, intMode, softRstPulse;
  int tests = 0, fails = 0, swCnt = 0, oeLow = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (softRstPulse) swCnt <= swCnt + 1;

  spi_reg_port i_spi_reg_port (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ssN), .mosi(mosi),
    .angle(angle), .alarmLo(alarmLo), .alarmHi(alarmHi),
    .miso(miso), .misoOe(misoOe), .intMode(intMode),
    .softRstPulse(softRstPulse)
  );

  function automatic logic [15:0] mk(input logic [14:0] u);
    return {u, ^u};
  endfunction
  function automatic logic [15:0] cmdW(input logic rd, input logic [13:0] a);
    return mk({rd, a});
  endfunction
  function automatic logic [15:0] rspW(input logic [13:0] d, input logic e);
    return mk({d, e});
  endfunction

  typedef struct packed {
    logic [15:0] tx;
    logic [15:0] rx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{cmdW(1, 14'h3FFF),          rspW(0, 0),        8'd1},  // R1 first frame zero
    '{cmdW(0, 14'h0000),          rspW(14'h06A5, 0), 8'd3},  // R3 angle word
    '{cmdW(0, 14'h3F20),          rspW(0, 0),        8'd9},  // R9 NOP answer
    '{rspW(14'h0001, 0),          rspW(0, 0),        8'd4},  // R4 old content
    '{cmdW(0, 14'h0000),          rspW(14'h0001, 0), 8'd4},  // R4 new content
    '{cmdW(1, 14'h3F20),          rspW(0, 0),        8'd9},
    '{cmdW(0, 14'h0000),          rspW(14'h0001, 0), 8'd4},  // R4 readback
    '{cmdW(1, 14'h1234),          rspW(0, 0),        8'd9},
    '{cmdW(0, 14'h0000),          rspW(0, 1),        8'd6},  // R6 unknown address
    '{cmdW(0, 14'h0000),          rspW(0, 1),        8'd8},  // R8 sticky
    '{cmdW(1, 14'h3380),          rspW(0, 1),        8'd8},
    '{cmdW(0, 14'h0000),          rspW(0, 0),        8'd8},  // R8 cleared
    '{cmdW(1, 14'h3FFF) ^ 16'd1,  rspW(0, 0),        8'd9},
    '{cmdW(0, 14'h0000),          rspW(0, 1),        8'd5},  // R5 bad parity
    '{cmdW(1, 14'h3380),          rspW(0, 1),        8'd8},
    '{cmdW(0, 14'h3FFF),          rspW(0, 0),        8'd8},
    '{cmdW(0, 14'h0000),          rspW(0, 1),        8'd6},  // R6 write read-only
    '{cmdW(1, 14'h3380),          rspW(0, 1),        8'd8},
    '{cmdW(0, 14'h0000),          rspW(0, 0),        8'd8},
    '{cmdW(0, 14'h3F20) ^ 16'd1,  rspW(0, 0),        8'd9},
    '{rspW(14'h0000, 0),          rspW(0, 1),        8'd5},  // R5 no data phase
    '{cmdW(1, 14'h3380),          rspW(0, 1),        8'd5},
    '{cmdW(1, 14'h3F20),          rspW(0, 0),        8'd8},
    '{cmdW(0, 14'h0000),          rspW(14'h0001, 0), 8'd5}   // R5 config kept
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, output logic [15:0] got);
    got = '0;
    ssN = 1'b0;
    #HALF;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      sck  = 1'b1;
      #HALF;
      if (i < 16) got[15-i] = miso;
      if (!misoOe) oeLow++;
      sck = 1'b0;
      #HALF;
    end
    ssN = 1'b1;
    #(HALF*2);
  endtask

  task automatic xfer(input logic [15:0] w, input logic [15:0] exp, input string req);
    logic [15:0] got;
    frame(w, 16, got);
    check(got == exp, req, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(intMode == 1'b0, "R1 intMode", intMode, 0);
    check(misoOe == 1'b0, "R2 idle oe", misoOe, 0);

    for (int v = 0; v < NV; v++) begin
      frame(VECS[v].tx, 16, got);
      check(got == VECS[v].rx, $sformatf("R%0d vector %0d", VECS[v].req, v), got, VECS[v].rx);
    end
    check(intMode == 1'b1, "R4 intMode set", intMode, 1);
    check(oeLow == 0, "R2 oe during frames", oeLow, 0);
    check(misoOe == 1'b0, "R2 oe after frame", misoOe, 0);

    // R10: reset without interface reset
    xfer(cmdW(1, 14'h1111), rspW(0, 0), "R9");
    xfer(cmdW(0, 14'h3C00), rspW(0, 1), "R6");
    xfer(rspW(14'h0000, 0), rspW(0, 1), "R10 reset cmd reply");
    check(swCnt == 1, "R10 pulse count", swCnt, 1);
    check(intMode == 1'b1, "R10 config kept", intMode, 1);
    xfer(cmdW(0, 14'h0000), rspW(0, 1), "R10 error kept");
    // R10: reset including interface registers
    xfer(cmdW(0, 14'h3C00), rspW(0, 1), "R10");
    xfer(rspW(14'h0001, 0), rspW(0, 1), "R10 reset cmd reply");
    check(swCnt == 2, "R10 pulse count", swCnt, 2);
    check(intMode == 1'b0, "R10 config reset", intMode, 0);
    xfer(cmdW(0, 14'h0000), rspW(0, 0), "R10 error reset");

    // R7: short and long frames
    frame(16'h0000, 12, got);
    xfer(cmdW(0, 14'h0000), rspW(0, 1), "R7 short frame");
    xfer(cmdW(1, 14'h3380), rspW(0, 1), "R8");
    xfer(cmdW(0, 14'h0000), rspW(0, 0), "R8 cleared");
    frame(16'h0000, 20, got);
    xfer(cmdW(0, 14'h0000), rspW(0, 1), "R7 long frame");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule